// File: doc/BRIEF.md
# Frame Buffer Dirty Band Tracker

This block watches the write traffic going into a frame buffer and records which horizontal bands of the picture have changed since the last screen refresh. A band is four scan lines tall, and one tracking bit stands for each band. The frame buffer can hold up to three planes: an 8-bit index plane, a direct-colour plane and a control plane. The direct-colour and control planes store four bytes per pixel, so one band of either spans four times the byte range of an index-plane band. A band is dirty when any plane has a dirty bit set for it.

When a refresh is requested, the block walks every band in ascending order, one band per clock cycle. It merges each maximal run of consecutive dirty bands into a single full-width rectangle and hands that rectangle to the display side over a valid/ready handshake. While the display side holds ready low, the walk waits. After the last band, the block clears one contiguous range of tracking bits in all planes: from the lowest dirty band it found to the highest. An invalidate pulse marks the whole frame dirty, so the next walk repaints everything.

Top module: `fb_band_tracker`

## Requirements
- R1: After reset, `rect_valid` and `walk_busy` are low, every band is clean, and the first walk emits no rectangle. `rect_valid` is never high while `walk_busy` is low.
- R2: An index-plane write at byte address A marks band A / (LINES_PER_BAND * LINE_BYTES) dirty. With the defaults the divisor is 4096.
- R3: When `deep_mode` is 1, a direct-plane or control-plane write at byte address A marks band A / (4 * LINES_PER_BAND * LINE_BYTES) dirty in that plane. With the defaults the divisor is 16384. The walk treats a band as dirty if any of the three planes has it dirty.
- R4: When `deep_mode` is 0, direct-plane and control-plane writes are ignored and leave no dirty band behind.
- R5: A walk emits one rectangle for each maximal run of consecutive dirty bands, in ascending order. `rect_y` is the first band times LINES_PER_BAND, `rect_h` is the run length times LINES_PER_BAND, and `rect_w` equals ACTIVE_WIDTH. The horizontal origin is always column 0.
- R6: A run that reaches the last band is emitted at the end of the walk. This also holds for a run made of the last band alone.
- R7: At the end of a walk, all planes are cleared from the lowest to the highest dirty band seen during the walk. Nothing is cleared if no band was dirty, so a second walk with no new writes emits nothing.
- R8: A write that lands during a walk on a band the walk has already passed is lost if that band lies inside the cleared range, and survives into the next walk if it lies outside that range.
- R9: An `invalidate` pulse marks every band dirty, so the next walk emits one rectangle with `rect_y` = 0 and `rect_h` = NUM_BANDS * LINES_PER_BAND.
- R10: While `rect_valid` is high and `rect_ready` is low, the rectangle outputs hold steady and the walk does not advance.
- R11: A `refresh_req` raised while a walk is in progress is ignored; no second walk follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deep_mode | input | 1 | Enables tracking of the direct and control planes |
| invalidate | input | 1 | Marks every band dirty |
| idx_wr_vld | input | 1 | Index-plane write seen |
| idx_wr_addr | input | IDX_AW | Index-plane byte address |
| dir_wr_vld | input | 1 | Direct-plane write seen |
| dir_wr_addr | input | DEEP_AW | Direct-plane byte address |
| ctl_wr_vld | input | 1 | Control-plane write seen |
| ctl_wr_addr | input | DEEP_AW | Control-plane byte address |
| refresh_req | input | 1 | Starts a walk when the block is idle |
| walk_busy | output | 1 | A walk is in progress |
| rect_valid | output | 1 | Update rectangle available |
| rect_ready | input | 1 | Display side accepts the rectangle |
| rect_y | output | LINE_W | First scan line of the rectangle |
| rect_h | output | LINE_W | Height of the rectangle in scan lines |
| rect_w | output | WID_W | Width of the rectangle (full active width) |

## Verification
A corrupted tracking bit shows up at the next walk. It appears as a missing, extra or wrongly merged rectangle, or as a rectangle whose `rect_y` or `rect_h` is off by a multiple of four lines. That comparison happens on the first handshake that involves the affected band. A wrong clear range shows one walk later: bands that should have survived disappear, or cleared bands come back. Faults in the walk sequencer show in the same clock at the handshake. These faults include losing the open run at the last band or moving while the display side stalls, and the per-clock check on held outputs catches them.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_SCAN  = 2'd1,
      WK_EMIT  = 2'd2,
      WK_CLEAR = 2'd3
   } walk_state_e;

   localparam int PLANE_CNT = 3;

endpackage

// File: rtl/fbt_plane_bits.sv
module fbt_plane_bits #(
   parameter int NUM_BANDS = 16,
   localparam int BW = $clog2(NUM_BANDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_vld,
   input  logic [BW-1:0]        set_idx,
   input  logic                 set_all,
   input  logic                 clr_vld,
   input  logic [BW-1:0]        clr_lo,
   input  logic [BW-1:0]        clr_hi,
   output logic [NUM_BANDS-1:0] bits
);

   for (genvar i = 0; i < NUM_BANDS; i++) begin : g_bit
      logic in_rng;
      logic hit;

      assign in_rng = (int'(clr_lo) <= i) && (i <= int'(clr_hi));
      assign hit    = set_all || (set_vld && (set_idx == BW'(i)));

      // the range clear takes priority over a set in the same cycle
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bits[i] <= 1'b0;
         end else if (clr_vld && in_rng) begin
            bits[i] <= 1'b0;
         end else if (hit) begin
            bits[i] <= 1'b1;
         end
      end

      // R7
      range_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vld && in_rng) |=> !bits[i]);
   end

endmodule

// File: rtl/fbt_walker.sv
module fbt_walker
   import fbt_pkg::*;
#(
   parameter int NUM_BANDS      = 16,
   parameter int LINES_PER_BAND = 4,
   localparam int BW          = $clog2(NUM_BANDS),
   localparam int FRAME_LINES = NUM_BANDS * LINES_PER_BAND,
   localparam int LINE_W      = $clog2(FRAME_LINES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 refresh_req,
   input  logic [NUM_BANDS-1:0] band_dirty,
   output logic                 busy,
   output logic                 rect_valid,
   input  logic                 rect_ready,
   output logic [LINE_W-1:0]    rect_y,
   output logic [LINE_W-1:0]    rect_h,
   output logic                 clr_vld,
   output logic [BW-1:0]        clr_lo,
   output logic [BW-1:0]        clr_hi
);

   walk_state_e   state;
   logic [BW-1:0] ptr;
   logic [BW-1:0] run_start;
   logic          run_open;
   logic          seen_dirty;
   logic          scan_done;

   logic          cur_dirty;
   logic          at_last;
   logic          emit_now;
   logic [BW-1:0] start_sel;
   logic [BW:0]   end_x;

   assign cur_dirty = band_dirty[ptr];
   assign at_last   = (ptr == BW'(NUM_BANDS - 1));
   assign emit_now  = (run_open && !cur_dirty) || (cur_dirty && at_last);
   assign start_sel = run_open ? run_start : ptr;
   assign end_x     = cur_dirty ? ({1'b0, ptr} + 1'b1) : {1'b0, ptr};

   assign busy    = (state != WK_IDLE);
   assign clr_vld = (state == WK_CLEAR) && seen_dirty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= WK_IDLE;
         ptr        <= '0;
         run_start  <= '0;
         run_open   <= 1'b0;
         seen_dirty <= 1'b0;
         scan_done  <= 1'b0;
         clr_lo     <= '0;
         clr_hi     <= '0;
         rect_valid <= 1'b0;
         rect_y     <= '0;
         rect_h     <= '0;
      end else begin
         case (state)
            WK_IDLE: begin
               if (refresh_req) begin
                  state      <= WK_SCAN;
                  ptr        <= '0;
                  run_open   <= 1'b0;
                  seen_dirty <= 1'b0;
                  scan_done  <= 1'b0;
               end
            end
            WK_SCAN: begin
               if (cur_dirty) begin
                  seen_dirty <= 1'b1;
                  clr_hi     <= ptr;
                  if (!seen_dirty) begin
                     clr_lo <= ptr;
                  end
               end
               if (emit_now) begin
                  rect_valid <= 1'b1;
                  rect_y     <= LINE_W'(start_sel) * LINE_W'(LINES_PER_BAND);
                  rect_h     <= LINE_W'(end_x - {1'b0, start_sel}) * LINE_W'(LINES_PER_BAND);
                  run_open   <= 1'b0;
                  scan_done  <= at_last;
                  state      <= WK_EMIT;
               end else begin
                  if (cur_dirty && !run_open) begin
                     run_open  <= 1'b1;
                     run_start <= ptr;
                  end
                  state <= at_last ? WK_CLEAR : WK_SCAN;
               end
               if (!at_last) begin
                  ptr <= ptr + 1'b1;
               end
            end
            WK_EMIT: begin
               if (rect_ready) begin
                  rect_valid <= 1'b0;
                  state      <= scan_done ? WK_CLEAR : WK_SCAN;
               end
            end
            default: begin
               state <= WK_IDLE;
            end
         endcase
      end
   end

   // R10
   rect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rect_valid && !rect_ready) |=> (rect_valid && $stable(rect_y) && $stable(rect_h)));

   // R5
   rect_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rect_valid |-> ((rect_h != '0) && ((int'(rect_y) + int'(rect_h)) <= FRAME_LINES)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rect_valid);

   // R7
   clear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vld |-> (clr_lo <= clr_hi));

   // R11
   single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && refresh_req) |=> ($past(ptr) <= ptr || !busy || state == WK_EMIT || state == WK_CLEAR));

endmodule

// File: rtl/fb_band_tracker.sv
module fb_band_tracker
   import fbt_pkg::*;
#(
   parameter int NUM_BANDS      = 16,
   parameter int LINES_PER_BAND = 4,
   parameter int LINE_BYTES     = 1024,
   parameter int ACTIVE_WIDTH   = 1024,
   localparam int BW          = $clog2(NUM_BANDS),
   localparam int BAND_SH     = $clog2(LINES_PER_BAND * LINE_BYTES),
   localparam int IDX_AW      = BW + BAND_SH,
   localparam int DEEP_AW     = IDX_AW + 2,
   localparam int LINE_W      = $clog2(NUM_BANDS * LINES_PER_BAND + 1),
   localparam int WID_W       = $clog2(ACTIVE_WIDTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               deep_mode,
   input  logic               invalidate,
   input  logic               idx_wr_vld,
   input  logic [IDX_AW-1:0]  idx_wr_addr,
   input  logic               dir_wr_vld,
   input  logic [DEEP_AW-1:0] dir_wr_addr,
   input  logic               ctl_wr_vld,
   input  logic [DEEP_AW-1:0] ctl_wr_addr,
   input  logic               refresh_req,
   output logic               walk_busy,
   output logic               rect_valid,
   input  logic               rect_ready,
   output logic [LINE_W-1:0]  rect_y,
   output logic [LINE_W-1:0]  rect_h,
   output logic [WID_W-1:0]   rect_w
);

   // elaboration-time parameter checks
   if (NUM_BANDS < 2 || (NUM_BANDS & (NUM_BANDS - 1)) != 0) begin : g_bad_bands
      $error("NUM_BANDS must be a power of two, at least 2");
   end
   if (LINES_PER_BAND < 1 || ((LINES_PER_BAND * LINE_BYTES) & (LINES_PER_BAND * LINE_BYTES - 1)) != 0) begin : g_bad_band_bytes
      $error("LINES_PER_BAND * LINE_BYTES must be a power of two");
   end
   if (ACTIVE_WIDTH < 1 || ACTIVE_WIDTH > LINE_BYTES) begin : g_bad_width
      $error("ACTIVE_WIDTH must lie in 1..LINE_BYTES");
   end

   logic [PLANE_CNT-1:0] pl_set_vld;
   logic [BW-1:0]        pl_set_idx [PLANE_CNT];
   logic [NUM_BANDS-1:0] pl_bits    [PLANE_CNT];
   logic [NUM_BANDS-1:0] any_dirty;
   logic                 clr_vld;
   logic [BW-1:0]        clr_lo;
   logic [BW-1:0]        clr_hi;
   logic                 unused_low_bits;

   // only the band-selecting address bits matter
   assign unused_low_bits = ^{idx_wr_addr[BAND_SH-1:0],
                              dir_wr_addr[BAND_SH+1:0],
                              ctl_wr_addr[BAND_SH+1:0]};

   assign pl_set_vld[0] = idx_wr_vld;
   assign pl_set_idx[0] = idx_wr_addr[IDX_AW-1:BAND_SH];
   assign pl_set_vld[1] = dir_wr_vld && deep_mode;
   assign pl_set_idx[1] = dir_wr_addr[DEEP_AW-1:BAND_SH+2];
   assign pl_set_vld[2] = ctl_wr_vld && deep_mode;
   assign pl_set_idx[2] = ctl_wr_addr[DEEP_AW-1:BAND_SH+2];

   for (genvar p = 0; p < PLANE_CNT; p++) begin : g_plane
      fbt_plane_bits #(
         .NUM_BANDS (NUM_BANDS)
      ) u_bits (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_vld (pl_set_vld[p]),
         .set_idx (pl_set_idx[p]),
         .set_all (invalidate && (p == 0)),
         .clr_vld (clr_vld),
         .clr_lo  (clr_lo),
         .clr_hi  (clr_hi),
         .bits    (pl_bits[p])
      );
   end

   always_comb begin
      any_dirty = '0;
      for (int p = 0; p < PLANE_CNT; p++) begin
         any_dirty = any_dirty | pl_bits[p];
      end
   end

   fbt_walker #(
      .NUM_BANDS      (NUM_BANDS),
      .LINES_PER_BAND (LINES_PER_BAND)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .refresh_req (refresh_req),
      .band_dirty  (any_dirty),
      .busy        (walk_busy),
      .rect_valid  (rect_valid),
      .rect_ready  (rect_ready),
      .rect_y      (rect_y),
      .rect_h      (rect_h),
      .clr_vld     (clr_vld),
      .clr_lo      (clr_lo),
      .clr_hi      (clr_hi)
   );

   assign rect_w = WID_W'(ACTIVE_WIDTH);

   // R4
   shallow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!deep_mode && !clr_vld) |=> ((pl_bits[1] == $past(pl_bits[1])) && (pl_bits[2] == $past(pl_bits[2]))));

   // R9
   invalidate_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (invalidate && !clr_vld) |=> (&pl_bits[0]));

endmodule

// File: tb/sim_fb_band_tracker.sv
`timescale 1ns/1ps
module sim_fb_band_tracker;

   localparam int NB      = 16;
   localparam int LPB     = 4;
   localparam int BBYTES  = 4096;
   localparam int IDX_AW  = 16;
   localparam int DEEP_AW = 18;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               deep_mode = 1'b0;
   logic               invalidate = 1'b0;
   logic               idx_wr_vld = 1'b0;
   logic [IDX_AW-1:0]  idx_wr_addr = '0;
   logic               dir_wr_vld = 1'b0;
   logic [DEEP_AW-1:0] dir_wr_addr = '0;
   logic               ctl_wr_vld = 1'b0;
   logic [DEEP_AW-1:0] ctl_wr_addr = '0;
   logic               refresh_req = 1'b0;
   logic               walk_busy;
   logic               rect_valid;
   logic               rect_ready = 1'b1;
   logic [6:0]         rect_y;
   logic [6:0]         rect_h;
   logic [10:0]        rect_w;

   fb_band_tracker u0 (
      .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode), .invalidate(invalidate),
      .idx_wr_vld(idx_wr_vld), .idx_wr_addr(idx_wr_addr),
      .dir_wr_vld(dir_wr_vld), .dir_wr_addr(dir_wr_addr),
      .ctl_wr_vld(ctl_wr_vld), .ctl_wr_addr(ctl_wr_addr),
      .refresh_req(refresh_req), .walk_busy(walk_busy),
      .rect_valid(rect_valid), .rect_ready(rect_ready),
      .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w)
   );

   always #2 clk = ~clk;

   int    vectors = 0;
   int    miscompares = 0;
   int    cycles = 0;
   bit    mon_on = 1'b0;
   string cur_req = "R1";

   int    m_dirty [3][NB];
   int    q_y[$];
   int    q_h[$];
   int    w_lo, w_hi;
   bit    w_any;

   bit    prev_stall = 1'b0;
   int    prev_y, prev_h;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         miscompares++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         finish_run();
      end
   end

   // per-clock comparison against the behavioural model
   always begin
      @(negedge clk);
      #1;
      if (mon_on) begin
         chk(walk_busy || !rect_valid, "R1", "valid while idle", int'(rect_valid), 0);
         if (prev_stall) begin
            chk(rect_valid == 1'b1, "R10", "valid dropped in stall", int'(rect_valid), 1);
            chk(int'(rect_y) == prev_y, "R10", "y moved in stall", int'(rect_y), prev_y);
            chk(int'(rect_h) == prev_h, "R10", "h moved in stall", int'(rect_h), prev_h);
         end
         if (rect_valid && rect_ready) begin
            if (q_y.size() == 0) begin
               chk(1'b0, cur_req, "unexpected rect y", int'(rect_y), -1);
            end else begin
               int ey, eh;
               ey = q_y.pop_front();
               eh = q_h.pop_front();
               chk(int'(rect_y) == ey, cur_req, "rect y", int'(rect_y), ey);
               chk(int'(rect_h) == eh, cur_req, "rect h", int'(rect_h), eh);
               chk(int'(rect_w) == 1024, "R5", "rect w", int'(rect_w), 1024);
            end
         end
         prev_stall = rect_valid && !rect_ready;
         prev_y     = int'(rect_y);
         prev_h     = int'(rect_h);
      end
   end

   task automatic snoop(input int plane, input int addr);
      @(negedge clk);
      case (plane)
         0: begin idx_wr_vld = 1'b1; idx_wr_addr = IDX_AW'(addr); end
         1: begin dir_wr_vld = 1'b1; dir_wr_addr = DEEP_AW'(addr); end
         default: begin ctl_wr_vld = 1'b1; ctl_wr_addr = DEEP_AW'(addr); end
      endcase
      @(negedge clk);
      idx_wr_vld = 1'b0;
      dir_wr_vld = 1'b0;
      ctl_wr_vld = 1'b0;
      if (plane == 0) m_dirty[0][addr / BBYTES] = 1;
      else if (deep_mode) m_dirty[plane][addr / (4 * BBYTES)] = 1;
   endtask

   task automatic inval();
      @(negedge clk);
      invalidate = 1'b1;
      @(negedge clk);
      invalidate = 1'b0;
      for (int b = 0; b < NB; b++) m_dirty[0][b] = 1;
   endtask

   task automatic start_walk(input string req);
      int run_s;
      @(negedge clk);
      cur_req = req;
      refresh_req = 1'b1;
      run_s = -1;
      w_any = 1'b0;
      for (int b = 0; b <= NB; b++) begin
         bit d;
         d = (b < NB) && ((m_dirty[0][b] | m_dirty[1][b] | m_dirty[2][b]) != 0);
         if (d) begin
            if (!w_any) w_lo = b;
            w_any = 1'b1;
            w_hi = b;
            if (run_s < 0) run_s = b;
         end else if (run_s >= 0) begin
            q_y.push_back(run_s * LPB);
            q_h.push_back((b - run_s) * LPB);
            run_s = -1;
         end
      end
      @(negedge clk);
      refresh_req = 1'b0;
      #1;
      chk(walk_busy == 1'b1, req, "busy after request", int'(walk_busy), 1);
   endtask

   task automatic finish_walk(input int stall_mod, input bit poke);
      int cyc;
      cyc = 0;
      forever begin
         @(negedge clk);
         rect_ready  = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) == 0);
         refresh_req = poke && (cyc == 3);
         #1;
         if (!walk_busy) break;
         cyc++;
      end
      refresh_req = 1'b0;
      rect_ready  = 1'b1;
      chk(q_y.size() == 0, cur_req, "rects left unsent", q_y.size(), 0);
      q_y.delete();
      q_h.delete();
      if (w_any) begin
         for (int p = 0; p < 3; p++)
            for (int b = w_lo; b <= w_hi; b++) m_dirty[p][b] = 0;
      end
   endtask

   task automatic walk(input string req, input int stall_mod);
      start_walk(req);
      finish_walk(stall_mod, 1'b0);
   endtask

   initial begin
      for (int p = 0; p < 3; p++)
         for (int b = 0; b < NB; b++) m_dirty[p][b] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(rect_valid == 1'b0, "R1", "rect_valid after reset", int'(rect_valid), 0);
      chk(walk_busy == 1'b0, "R1", "walk_busy after reset", int'(walk_busy), 0);
      mon_on = 1'b1;
      walk("R1", 0);

      // R2 index plane band mapping
      snoop(0, 3 * BBYTES + 1023);
      snoop(0, 4 * BBYTES - 1);
      snoop(0, 7 * BBYTES);
      snoop(0, 8 * BBYTES + 5);
      walk("R2", 0);
      walk("R7", 0);

      // R5 several runs with a stalling consumer (R10)
      snoop(0, 0); snoop(0, 1 * BBYTES); snoop(0, 2 * BBYTES);
      snoop(0, 5 * BBYTES); snoop(0, 9 * BBYTES); snoop(0, 10 * BBYTES + 77);
      walk("R5", 3);
      snoop(0, 6 * BBYTES); snoop(0, 8 * BBYTES);
      walk("R10", 4);

      // R6 runs touching the last band
      snoop(0, 14 * BBYTES); snoop(0, 15 * BBYTES + 4095);
      walk("R6", 0);
      snoop(0, 15 * BBYTES);
      walk("R6", 2);
      snoop(0, 0); snoop(0, 15 * BBYTES);
      walk("R6", 0);

      // R3 deep planes
      deep_mode = 1'b1;
      snoop(1, 5 * 4 * BBYTES + 7);
      snoop(2, 9 * 4 * BBYTES + 16383);
      snoop(0, 6 * BBYTES);
      walk("R3", 0);
      walk("R7", 0);

      // R4 deep planes ignored when shallow
      deep_mode = 1'b0;
      snoop(1, 7 * 4 * BBYTES);
      snoop(2, 2 * 4 * BBYTES);
      snoop(0, 1 * BBYTES);
      walk("R4", 0);
      walk("R4", 0);

      // R9 invalidate
      inval();
      walk("R9", 0);
      walk("R7", 0);

      // R8 writes behind the walk pointer
      snoop(0, 2 * BBYTES); snoop(0, 3 * BBYTES); snoop(0, 10 * BBYTES);
      rect_ready = 1'b0;
      start_walk("R8");
      do begin
         @(negedge clk);
         #1;
      end while (!rect_valid);
      snoop(0, 1 * BBYTES);
      snoop(0, 3 * BBYTES);
      finish_walk(0, 1'b0);
      walk("R8", 0);

      // R11 request during a walk is ignored
      snoop(0, 4 * BBYTES);
      start_walk("R11");
      finish_walk(0, 1'b1);
      repeat (3) begin
         @(negedge clk);
         #1;
         chk(walk_busy == 1'b0, "R11", "extra walk started", int'(walk_busy), 0);
      end
      walk("R11", 0);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule